// File: doc/BRIEF.md
# Per-Channel Output Enable and Control-Bit Serialiser

This block decides, for every channel slot of a TDM frame, which of the serial output streams may drive their lines. It also sends a one-bit control stream that external line circuitry can use. Two global inputs set the gating mode. A pin-level drive enable forces every stream to high impedance when it is low. When the drive enable is high, an all-active control bit either turns every stream on, or hands control to a per-channel, per-stream enable bit that the block stores.

Each stored location also holds a second bit, the control bit. Once per frame this bit is shifted out on `ctrl_bit_o`. It goes out during the channel slot just before the channel it belongs to, so that external logic has one full channel of lead time. Inside that slot the bits of the streams are sent one per bit time, starting with stream 0. A frame has `NUM_CHANNELS` channels, and each channel has `NUM_STREAMS` bit times. The stored bits are loaded through a simple write port.

Top module: `tdm_chan_oe`

## Requirements
- R1: If `drive_en_i` is low at the clock edge that starts a channel slot, `stream_oe_o` is all zeros for that entire slot.
- R2: If `drive_en_i` is high and `all_active_i` is high at the edge that starts a slot, every bit of `stream_oe_o` is 1 for that slot.
- R3: If `drive_en_i` is high and `all_active_i` is low at the edge that starts a slot, bit s of `stream_oe_o` equals the stored enable bit for stream s in that slot's channel (1 = drive, 0 = high impedance).
- R4: `stream_oe_o` changes only on the first bit time of a channel. Changes on `drive_en_i`, `all_active_i` or the stored enables during a slot have no effect until the next slot starts.
- R5: During channel c, `ctrl_bit_o` carries the stored control bits of channel c+1. During channel NUM_CHANNELS-1 it carries those of channel 0.
- R6: Within a channel slot, bit time k (k = 0 is the first bit time) carries the control bit of stream k.
- R7: When `frame_sync_i` is high at a clock edge, the cycle after that edge is channel 0, bit time 0. Otherwise the slot position advances by one bit time per clock and wraps from the last bit of channel NUM_CHANNELS-1 to channel 0, bit 0.
- R8: When `cm_we_i` is high at an edge, `cm_oe_i` and `cm_cs_i` are stored for (`cm_stream_i`, `cm_chan_i`). Any slot loaded at a later edge sees the new values. A slot loaded at the same edge still sees the old values.
- R9: After reset, every stored bit is 0, and `stream_oe_o` and `ctrl_bit_o` are 0. The position is the last bit of the last channel, so the first cycle after reset is channel 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-time clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_sync_i | input | 1 | Realigns the next cycle to channel 0, bit 0 |
| drive_en_i | input | 1 | Global drive enable; low forces all streams off |
| all_active_i | input | 1 | When high with drive enable, all streams on |
| cm_we_i | input | 1 | Write strobe for the per-location bits |
| cm_chan_i | input | 5 | Channel of the location written |
| cm_stream_i | input | 3 | Stream of the location written |
| cm_oe_i | input | 1 | Enable bit to store |
| cm_cs_i | input | 1 | Control bit to store |
| stream_oe_o | output | 8 | Per-stream driver enable for the current slot |
| ctrl_bit_o | output | 1 | Serial control-bit stream |

## Verification
The bench runs a behavioural model of the frame position, the stored bits and the gating mode, and compares both outputs with it on every clock. Several corner cases are targeted:
- `drive_en_i` and `all_active_i` are toggled in the middle of a channel. A design that reacts immediately would leave a channel partly driven.
- Writes are made to the location whose slot is being loaded at that same edge. A design with the wrong read-before-write order would show the new value one slot early.
- Frames run across the channel wrap. A design that gets the look-ahead wrong would send channel 0's control bits during channel 0 instead of channel 31, or would shift the stream order within the slot.
- `frame_sync_i` is pulsed part-way through a frame. A counter that ignores it would drift away from the model's alignment.

// File: rtl/tdm_oe_pkg.sv
package tdm_oe_pkg;
  localparam int DEF_STREAMS  = 8;
  localparam int DEF_CHANNELS = 32;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ALL    = 2'd1,
    MODE_PER_CH = 2'd2
  } drive_mode_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int NC   = 32,
  parameter int NS   = 8,
  localparam int CH_W = $clog2(NC),
  localparam int BT_W = $clog2(NS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frame_sync_i,
  output logic [CH_W-1:0] nxt_ch_o,
  output logic [BT_W-1:0] nxt_bit_o,
  output logic            nxt_first_o
);
  localparam logic [CH_W-1:0] LAST_CH  = CH_W'(NC - 1);
  localparam logic [BT_W-1:0] LAST_BIT = BT_W'(NS - 1);

  logic [CH_W-1:0] cur_ch_q;
  logic [BT_W-1:0] cur_bit_q;

  always_comb begin
    if (frame_sync_i) begin
      nxt_ch_o  = '0;
      nxt_bit_o = '0;
    end else if (cur_bit_q == LAST_BIT) begin
      nxt_bit_o = '0;
      nxt_ch_o  = (cur_ch_q == LAST_CH) ? '0 : cur_ch_q + 1'b1;
    end else begin
      nxt_bit_o = cur_bit_q + 1'b1;
      nxt_ch_o  = cur_ch_q;
    end
  end

  assign nxt_first_o = (nxt_bit_o == '0);

  // reset parks on the final slot so the first live cycle is ch0/bit0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_ch_q  <= LAST_CH;
      cur_bit_q <= LAST_BIT;
    end else begin
      cur_ch_q  <= nxt_ch_o;
      cur_bit_q <= nxt_bit_o;
    end
  end

  AST_SYNC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sync_i |=> (cur_ch_q == '0 && cur_bit_q == '0)); // R7

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_sync_i && cur_ch_q == LAST_CH && cur_bit_q == LAST_BIT)
      |=> (cur_ch_q == '0 && cur_bit_q == '0)); // R7
endmodule

// File: rtl/tdm_ctl_table.sv
module tdm_ctl_table #(
  parameter int NC   = 32,
  parameter int NS   = 8,
  localparam int CH_W = $clog2(NC),
  localparam int ST_W = $clog2(NS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [ST_W-1:0] wr_st_i,
  input  logic            wr_oe_i,
  input  logic            wr_cs_i,
  input  logic [CH_W-1:0] oe_ch_i,
  output logic [NS-1:0]   oe_row_o,
  input  logic [CH_W-1:0] cs_ch_i,
  input  logic [ST_W-1:0] cs_st_i,
  output logic            cs_bit_o
);
  logic [NS-1:0] oe_mem [NC];
  logic [NS-1:0] cs_mem [NC];

  for (genvar c = 0; c < NC; c++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        oe_mem[c] <= '0;
        cs_mem[c] <= '0;
      end else if (we_i && wr_ch_i == CH_W'(c)) begin
        oe_mem[c][wr_st_i] <= wr_oe_i;
        cs_mem[c][wr_st_i] <= wr_cs_i;
      end
    end
  end

  assign oe_row_o = oe_mem[oe_ch_i];
  assign cs_bit_o = cs_mem[cs_ch_i][cs_st_i];

  AST_WR_CS_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cs_mem[$past(wr_ch_i)][$past(wr_st_i)] == $past(wr_cs_i)); // R8

  AST_WR_OE_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> oe_mem[$past(wr_ch_i)][$past(wr_st_i)] == $past(wr_oe_i)); // R8
endmodule

// File: rtl/tdm_oe_gate.sv
module tdm_oe_gate
  import tdm_oe_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          drive_en_i,
  input  logic          all_active_i,
  input  logic [NS-1:0] chan_oe_i,
  output logic [NS-1:0] oe_o
);
  drive_mode_e   mode;
  logic [NS-1:0] oe_d;

  always_comb begin
    if (!drive_en_i)       mode = MODE_OFF;
    else if (all_active_i) mode = MODE_ALL;
    else                   mode = MODE_PER_CH;
  end

  always_comb begin
    unique case (mode)
      MODE_OFF:    oe_d = '0;
      MODE_ALL:    oe_d = '1;
      MODE_PER_CH: oe_d = chan_oe_i;
      default:     oe_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     oe_o <= '0;
    else if (load_i) oe_o <= oe_d;
  end

  AST_OE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(oe_o)); // R4

  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !drive_en_i) |=> (oe_o == '0)); // R1

  AST_OE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && drive_en_i && all_active_i) |=> (oe_o == '1)); // R2

  AST_OE_PER_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && drive_en_i && !all_active_i) |=> (oe_o == $past(chan_oe_i))); // R3
endmodule

// File: rtl/tdm_chan_oe.sv
module tdm_chan_oe
  import tdm_oe_pkg::*;
#(
  parameter int NUM_STREAMS  = DEF_STREAMS,
  parameter int NUM_CHANNELS = DEF_CHANNELS,
  localparam int CH_W = $clog2(NUM_CHANNELS),
  localparam int ST_W = $clog2(NUM_STREAMS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_sync_i,
  input  logic                   drive_en_i,
  input  logic                   all_active_i,
  input  logic                   cm_we_i,
  input  logic [CH_W-1:0]        cm_chan_i,
  input  logic [ST_W-1:0]        cm_stream_i,
  input  logic                   cm_oe_i,
  input  logic                   cm_cs_i,
  output logic [NUM_STREAMS-1:0] stream_oe_o,
  output logic                   ctrl_bit_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CHANNELS - 1);

  logic [CH_W-1:0]        nxt_ch;
  logic [ST_W-1:0]        nxt_bit;
  logic                   nxt_first;
  logic [CH_W-1:0]        ahead_ch;
  logic [NUM_STREAMS-1:0] chan_oe;
  logic                   cs_bit;

  tdm_slot_timer #(.NC(NUM_CHANNELS), .NS(NUM_STREAMS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_sync_i(frame_sync_i),
    .nxt_ch_o    (nxt_ch),
    .nxt_bit_o   (nxt_bit),
    .nxt_first_o (nxt_first)
  );

  // control bits run one channel ahead of the slot they describe
  assign ahead_ch = (nxt_ch == LAST_CH) ? '0 : nxt_ch + 1'b1;

  tdm_ctl_table #(.NC(NUM_CHANNELS), .NS(NUM_STREAMS)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cm_we_i),
    .wr_ch_i (cm_chan_i),
    .wr_st_i (cm_stream_i),
    .wr_oe_i (cm_oe_i),
    .wr_cs_i (cm_cs_i),
    .oe_ch_i (nxt_ch),
    .oe_row_o(chan_oe),
    .cs_ch_i (ahead_ch),
    .cs_st_i (nxt_bit),
    .cs_bit_o(cs_bit)
  );

  tdm_oe_gate #(.NS(NUM_STREAMS)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (nxt_first),
    .drive_en_i  (drive_en_i),
    .all_active_i(all_active_i),
    .chan_oe_i   (chan_oe),
    .oe_o        (stream_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_bit_o <= 1'b0;
    else         ctrl_bit_o <= cs_bit;
  end

  AST_AHEAD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nxt_ch == LAST_CH) |-> (ahead_ch == '0)); // R5

  AST_CTRL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ctrl_bit_o == $past(cs_bit))); // R6
endmodule

// File: tb/tdm_chan_oe_test.sv
`timescale 1ns/1ps
module tdm_chan_oe_test;
  localparam int NS = 8;
  localparam int NC = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_sync = 1'b0;
  logic          drive_en = 1'b0;
  logic          all_active = 1'b0;
  logic          cm_we = 1'b0;
  logic [4:0]    cm_chan = '0;
  logic [2:0]    cm_stream = '0;
  logic          cm_oe = 1'b0;
  logic          cm_cs = 1'b0;
  logic [NS-1:0] stream_oe;
  logic          ctrl_bit;

  always #2.5 clk = ~clk;

  tdm_chan_oe uut (
    .clk_i(clk), .rst_ni(rst_n), .frame_sync_i(frame_sync),
    .drive_en_i(drive_en), .all_active_i(all_active),
    .cm_we_i(cm_we), .cm_chan_i(cm_chan), .cm_stream_i(cm_stream),
    .cm_oe_i(cm_oe), .cm_cs_i(cm_cs),
    .stream_oe_o(stream_oe), .ctrl_bit_o(ctrl_bit)
  );

  // behavioural reference
  bit     m_oe [NC][NS];
  bit     m_cs [NC][NS];
  int     m_ch, m_bit, m_mode;
  bit     m_out_oe [NS];
  bit     m_ctrl;
  int     errors = 0, checks = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++)
        for (int s = 0; s < NS; s++) begin m_oe[c][s] = 0; m_cs[c][s] = 0; end
      for (int s = 0; s < NS; s++) m_out_oe[s] = 0;
      m_ch = NC - 1; m_bit = NS - 1; m_ctrl = 0; m_mode = 0;
    end else begin
      if (frame_sync) begin m_ch = 0; m_bit = 0; end
      else if (m_bit == NS - 1) begin m_bit = 0; m_ch = (m_ch + 1) % NC; end
      else m_bit = m_bit + 1;
      if (m_bit == 0) begin
        m_mode = !drive_en ? 1 : (all_active ? 2 : 3);
        for (int s = 0; s < NS; s++)
          m_out_oe[s] = (m_mode == 1) ? 0 : (m_mode == 2) ? 1 : m_oe[m_ch][s];
      end
      m_ctrl = m_cs[(m_ch + 1) % NC][m_bit];
      if (cm_we) begin
        m_oe[cm_chan][cm_stream] = cm_oe;
        m_cs[cm_chan][cm_stream] = cm_cs;
      end
    end
  end

  function automatic logic [NS-1:0] exp_oe();
    logic [NS-1:0] v;
    for (int s = 0; s < NS; s++) v[s] = m_out_oe[s];
    return v;
  endfunction

  task automatic compare();
    string tag;
    checks++;
    tag = (m_mode == 1) ? "R1 R4" : (m_mode == 2) ? "R2 R4" : (m_mode == 3) ? "R3 R4 R8" : "R9";
    if (stream_oe !== exp_oe()) begin
      errors++;
      $display("FAIL %s stream_oe ch=%0d bit=%0d actual=%b expected=%b",
               tag, m_ch, m_bit, stream_oe, exp_oe());
    end
    checks++;
    if (ctrl_bit !== m_ctrl) begin
      errors++;
      $display("FAIL R5 R6 R7 R8 ctrl_bit ch=%0d bit=%0d actual=%b expected=%b",
               m_ch, m_bit, ctrl_bit, m_ctrl);
    end
  endtask

  task automatic run(input int cycles, input int wr_pct, input int toggle_pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare();
      cm_we = (($urandom % 100) < wr_pct);
      cm_chan = 5'($urandom);
      cm_stream = 3'($urandom);
      cm_oe = 1'($urandom);
      cm_cs = 1'($urandom);
      if (($urandom % 100) < toggle_pct) drive_en = ~drive_en;
      if (($urandom % 100) < toggle_pct) all_active = ~all_active;
      frame_sync = 1'b0;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (stream_oe !== '0 || ctrl_bit !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset actual=%b/%b expected=0/0", stream_oe, ctrl_bit);
    end
    rst_n = 1'b1;
    // R9 R1: fill the table while everything is held off
    run(NC * NS * 2, 60, 0);
    // R2: all outputs active
    drive_en = 1'b1; all_active = 1'b1;
    run(NC * NS, 10, 0);
    // R3 R5 R6: per-channel gating
    all_active = 1'b0;
    run(NC * NS * 3, 20, 0);
    // R4: pin toggles mid-channel
    run(NC * NS * 3, 20, 15);
    // R7: resync part-way through frames
    for (int k = 0; k < 6; k++) begin
      run(37 + k * 11, 20, 5);
      @(negedge clk);
      compare();
      frame_sync = 1'b1;
    end
    run(NC * NS * 2, 30, 5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule